// File: doc/BRIEF.md
# Wait-Pin Edge Interrupt and GPIO Unit

This block sits beside an external memory bus controller. It watches a set of asynchronous wait-input pins and two single-cycle event strobes from the NAND engine. It merges them into one flat interrupt vector with sticky per-source status bits, per-source enables and a per-pin choice of edge. It drives a single summary interrupt.

Each wait pin passes through a two-flop synchroniser. The synchronised level can be read back as a general-purpose input. Software uses a small register port with a combinational read path. Through it, software reads the sources, clears status by writing ones, sets enables and selects edges.

The register map is as follows.
- Address 0 holds status. Writing 1 to a bit clears it.
- Address 1 holds the enables.
- Address 2 holds the edge selects.
- Address 3 holds the synchronised pin levels and is read-only.

Top module: `wpi_top`

## Requirements
- R1: Status bit 0 is the NAND FIFO-threshold event. Status bit 1 is the NAND terminal-count event. Status bit 2+i is an edge on wait pin i.
- R2: Each wait pin passes through two flops. Bit i of the GPIO register (address 3) shows the level of pin i two clocks after the pin changes.
- R3: Bits [2i+1:2i] of the edge register (address 2) set the trigger for pin i: 00 none, 01 rising, 10 falling, 11 both. A synchronised level change that does not match the selection sets no status.
- R4: An event strobe that is high at a rising clock edge sets its status bit at that edge.
- R5: A set status bit stays set until a write to address 0 with a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R6: When a source sets a bit in the same cycle that software clears it, the bit stays set.
- R7: irq_o is high exactly when some status bit and its enable bit (address 1) are both 1.
- R8: After reset, all status bits are 0, all enables are 0 and irq_o is low. Every pin's edge select is 01 (rising).
- R9: A read of an address above 3 returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_pin_i | input | NUM_WAIT | Asynchronous wait pins |
| fifo_evt_i | input | 1 | FIFO-threshold event strobe |
| tc_evt_i | input | 1 | Terminal-count event strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write enable |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench builds the block with its defaults: two wait pins, 32-bit data and a 3-bit address. This gives four interrupt sources, so every source number and all four edge-select codes can be exercised. The 3-bit address also leaves four unmapped addresses to probe. Both pins can be moved in the same cycle as an event strobe, which reaches the case of several sources setting at once. It also reaches a set that coincides with a software clear.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  localparam int ADR_STATUS = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_EDGE   = 2;
  localparam int ADR_GPIO   = 3;
  localparam int NUM_ENGINE_SRC = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/wpi_sync.sv
module wpi_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = async_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/wpi_edge.sv
module wpi_edge #(
  parameter int NUM_PINS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   level_i,
  input  logic [2*NUM_PINS-1:0] sel_i,
  output logic [NUM_PINS-1:0]   edge_o
);
  logic [NUM_PINS-1:0] prev_q, prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    logic [1:0] sel;
    assign sel  = sel_i[2*p +: 2];
    assign rise = level_i[p] & ~prev_q[p];
    assign fall = ~level_i[p] & prev_q[p];
    assign edge_o[p] = (rise & sel[0]) | (fall & sel[1]);

    // R3
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b00) |-> !edge_o[p]);
    // R3
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o[p] && sel == 2'b01) |-> level_i[p]);
    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o[p] && sel == 2'b10) |-> !level_i[p]);
  end
endmodule

// File: rtl/wpi_regs.sv
module wpi_regs
  import wpi_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  localparam int NUM_SRC = NUM_ENGINE_SRC + NUM_WAIT,
  localparam int SEL_W   = 2 * NUM_WAIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_WAIT-1:0] gpio_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  edge_sel_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] st_q, st_d, en_q, en_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               wr_st, wr_en, wr_sel;

  assign wr_st  = wr_i && (addr_i == ADDR_W'(ADR_STATUS));
  assign wr_en  = wr_i && (addr_i == ADDR_W'(ADR_ENABLE));
  assign wr_sel = wr_i && (addr_i == ADDR_W'(ADR_EDGE));

  always_comb begin
    st_d = st_q;
    if (wr_st) st_d = st_d & ~wdata_i[NUM_SRC-1:0];
    st_d = st_d | set_i;
    en_d  = wr_en  ? wdata_i[NUM_SRC-1:0] : en_q;
    sel_d = wr_sel ? wdata_i[SEL_W-1:0]   : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      sel_q <= {NUM_WAIT{EDGE_RISE}};
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADR_STATUS): rdata_o[NUM_SRC-1:0]  = st_q;
      ADDR_W'(ADR_ENABLE): rdata_o[NUM_SRC-1:0]  = en_q;
      ADDR_W'(ADR_EDGE):   rdata_o[SEL_W-1:0]    = sel_q;
      ADDR_W'(ADR_GPIO):   rdata_o[NUM_WAIT-1:0] = gpio_i;
      default:             rdata_o = '0;
    endcase
  end

  assign edge_sel_o = sel_q;
  assign irq_o      = |(st_q & en_q);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> (($past(st_q) & ~st_q) == '0));
  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i)));
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
  // R9
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i > ADDR_W'(ADR_GPIO)) |=> ($stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/wpi_top.sv
module wpi_top
  import wpi_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAIT-1:0] wait_pin_i,
  input  logic                fifo_evt_i,
  input  logic                tc_evt_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int NUM_SRC = NUM_ENGINE_SRC + NUM_WAIT;
  localparam int SEL_W   = 2 * NUM_WAIT;

  logic [NUM_WAIT-1:0] lvl, pin_edge;
  logic [SEL_W-1:0]    sel;
  logic [NUM_SRC-1:0]  src_set;

  wpi_sync #(.WIDTH(NUM_WAIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wait_pin_i), .sync_o(lvl));

  wpi_edge #(.NUM_PINS(NUM_WAIT)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .sel_i(sel), .edge_o(pin_edge));

  // R1: fixed source numbering
  assign src_set = {pin_edge, tc_evt_i, fifo_evt_i};

  wpi_regs #(.NUM_WAIT(NUM_WAIT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .gpio_i(lvl),
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .edge_sel_o(sel), .irq_o(irq_o));
endmodule

// File: tb/wpi_top_test.sv
module wpi_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  pins = 0;
  logic        fe = 0, te = 0;
  logic [2:0]  addr = 0;
  logic        wr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wpi_top uut (.clk(clk), .rst_n(rst_n), .wait_pin_i(pins), .fifo_evt_i(fe),
    .tc_evt_i(te), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  // {pins[1:0], te, fe, expected status[3:0]} with rising edges selected
  localparam logic [7:0] VEC [5] = '{
    8'b00_01_0001,   // R1 R4 fifo event -> bit0
    8'b01_00_0100,   // R1 pin0 rise -> bit2
    8'b11_10_1010,   // R1 pin1 rise + tc event
    8'b10_00_0000,   // R3 pin0 fall ignored under rising
    8'b00_11_0011    // R4 both events, pin1 fall ignored
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wrt(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    rd(0, d); check("R8 status", d, 0);
    rd(1, d); check("R8 enable", d, 0);
    rd(2, d); check("R8 edge sel", d, 32'h5);
    check("R8 irq", {31'b0, irq}, 0);

    foreach (VEC[i]) begin
      @(negedge clk);
      pins = VEC[i][7:6]; te = VEC[i][5]; fe = VEC[i][4];
      @(negedge clk); te = 0; fe = 0;
      settle();
      rd(0, d); check($sformatf("R1 vec%0d", i), d, {28'b0, VEC[i][3:0]});
      wrt(0, 32'hF);
    end

    // R2 GPIO latency: visible after two clocks, not one
    @(negedge clk); pins = 2'b10;
    @(negedge clk); rd(3, d); check("R2 gpio after 1", d, 0);
    @(negedge clk); rd(3, d); check("R2 gpio after 2", d, 32'h2);
    settle(); wrt(0, 32'hF);

    // R3 pin1 falling, pin0 both
    wrt(2, 32'b10_11);
    @(negedge clk); pins = 2'b01; settle();
    rd(0, d); check("R3 p0 rise both, p1 fall", d, 32'hC);
    wrt(0, 32'hF);
    @(negedge clk); pins = 2'b00; settle();
    rd(0, d); check("R3 p0 fall both", d, 32'h4);
    wrt(0, 32'hF);
    wrt(2, 32'b00_00);
    @(negedge clk); pins = 2'b11; settle();
    rd(0, d); check("R3 none", d, 0);

    // R5 partial W1C
    @(negedge clk); fe = 1; te = 1;
    @(negedge clk); fe = 0; te = 0;
    wrt(0, 32'h1);
    rd(0, d); check("R5 partial clear", d, 32'h2);
    wrt(0, 32'h0);
    rd(0, d); check("R5 zero write", d, 32'h2);

    // R7 masking
    check("R7 irq no enable", {31'b0, irq}, 0);
    wrt(1, 32'h1);
    check("R7 irq masked", {31'b0, irq}, 0);
    wrt(1, 32'h2);
    check("R7 irq on", {31'b0, irq}, 1);
    wrt(0, 32'h2);
    check("R7 irq after clear", {31'b0, irq}, 0);

    // R6 set beats clear
    @(negedge clk); addr = 0; wdata = 32'h1; wr = 1; fe = 1;
    @(negedge clk); wr = 0; fe = 0;
    rd(0, d); check("R6 set wins", d, 32'h1);

    // R9 unmapped addresses
    wrt(5, 32'hFFFF_FFFF);
    rd(5, d); check("R9 read unmapped", d, 0);
    rd(1, d); check("R9 enable kept", d, 32'h2);
    rd(2, d); check("R9 edge kept", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule